// File: doc/BRIEF.md
# Serial Link Test Pattern Generator

This block feeds one lane of a serializer with a 10-bit test word on every clock. A 3-bit mode input picks the word source. The block can be idle, or it can produce one of two pseudo-random bit sequences. It can also produce words built from a 10-bit programmable pattern: the pattern on every word, the pattern alternating with its complement, or a four-word cycle made of all zeros, the pattern, all ones and the pattern's complement. A valid flag marks the cycles in which the word is meaningful. Mode codes that are not defined fall back to the idle behaviour.

A separate error request lets a link test check that the far-end checker sees errors. A rising edge on that input inverts the least significant bit of exactly one output word, however long the request is held high.

The pseudo-random modes step their shift register ten times per word, and bit 0 of the word is the first bit generated. Any change of mode reseeds the register to all ones and restarts the patterned sequences at their first word. The output is registered. The word present after a clock edge reflects the mode, pattern and trigger sampled at that edge.

Top module: `tpg_lane`

## Requirements
- R1: While reset is high, and in the first cycle after reset, `word_o` is 0x000 and `valid_o` is 0.
- R2: When the mode sampled at an edge is 0 (off), 6 or 7, the output after that edge is `word_o`=0x000 and `valid_o`=0, whatever the pattern and trigger are.
- R3: When the mode sampled at an edge is 1 to 5, `valid_o` is 1 after that edge.
- R4: Mode 1 gives a 15-bit sequence. Each generated bit is state[14] XOR state[13], and that bit is shifted in at state[0]. Ten steps are taken per word, and the bit from step i goes to word bit i. The state is seeded to all ones when the mode changes.
- R5: Mode 2 gives a 7-bit sequence with the same rule using state[6] XOR state[5]. The seven low state bits are seeded to all ones when the mode changes. Ten steps are taken per word, and bit 0 is the earliest.
- R6: Mode 3 outputs `pat_i` on every word.
- R7: Mode 4 outputs `pat_i`, then ~`pat_i`, and keeps alternating. The first word after entering the mode is `pat_i`.
- R8: Mode 5 repeats the order 0x000, `pat_i`, 0x3FF, ~`pat_i`. The first word after entering the mode is 0x000.
- R9: If `trig_i` is high at an edge and was low at the previous edge, the word output after that edge has bit 0 inverted and all other bits unchanged. Later words are not affected while `trig_i` stays high. The inversion applies only in modes 1 to 5.
- R10: Changing the mode and then returning to an earlier mode restarts that mode's sequence from its first word. This includes the reseed of the pseudo-random state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Source select (0 off, 1 PRBS15, 2 PRBS7, 3 fixed, 4 balanced, 5 four-word cycle, 6/7 reserved) |
| pat_i | input | 10 | Programmable pattern |
| trig_i | input | 1 | Error request, rising-edge sensitive |
| word_o | output | 10 | Test word |
| valid_o | output | 1 | Word valid |

## Verification
The assertions check every cycle that off and reserved modes give a zero, invalid word and that defined modes give a valid one. They also check that fixed mode follows the pattern, that the balanced mode complements each word against the one before it when no error intervenes, and that a trigger edge in fixed mode flips only bit 0. The exact pseudo-random bit streams, the position of each mode's first word after a change, the four-word cycle order and the one-word-only effect of a held trigger can only be shown by the bench's directed scenarios against its own sequence model.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
    localparam int WORD_W  = 10;
    localparam int LFSR_W  = 15;
    localparam int SHORT_W = 7;
    localparam int PHASE_W = 2;

    typedef enum logic [2:0] {
        TPG_OFF    = 3'd0,
        TPG_PRBS15 = 3'd1,
        TPG_PRBS7  = 3'd2,
        TPG_FIXED  = 3'd3,
        TPG_BAL    = 3'd4,
        TPG_CYC4   = 3'd5
    } tpg_mode_e;

    typedef struct packed {
        logic [LFSR_W-1:0] state;
        logic [WORD_W-1:0] word;
    } prbs_res_t;

    function automatic logic mode_active(input logic [2:0] m);
        return (m >= 3'd1) && (m <= 3'd5);
    endfunction

    // Run the shift register WORD_W steps; bit i of word is step i's output.
    function automatic prbs_res_t prbs_run(input logic [LFSR_W-1:0] seed,
                                           input logic short_poly);
        prbs_res_t r;
        logic [LFSR_W-1:0] s;
        logic nb;
        s = seed;
        r.word = '0;
        for (int i = 0; i < WORD_W; i++) begin
            nb = short_poly ? (s[SHORT_W-1] ^ s[SHORT_W-2])
                            : (s[LFSR_W-1] ^ s[LFSR_W-2]);
            s = {s[LFSR_W-2:0], nb};
            r.word[i] = nb;
        end
        r.state = s;
        return r;
    endfunction
endpackage

// File: rtl/tpg_prbs.sv
module tpg_prbs
    import tpg_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              restart_i,
    input  logic              short_i,
    output logic [WORD_W-1:0] word_o
);
    logic [LFSR_W-1:0] state_q;
    logic [LFSR_W-1:0] start;
    prbs_res_t         res;

    always_comb begin
        start  = restart_i ? {LFSR_W{1'b1}} : state_q;
        res    = prbs_run(start, short_i);
        word_o = res.word;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= {LFSR_W{1'b1}};
        else       state_q <= res.state;
    end
endmodule

// File: rtl/tpg_seq.sv
module tpg_seq
    import tpg_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              restart_i,
    input  logic [2:0]        mode_i,
    input  logic [WORD_W-1:0] pat_i,
    output logic [WORD_W-1:0] word_o
);
    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] cur;

    always_comb begin
        cur = restart_i ? '0 : phase_q;
        unique case (mode_i)
            3'(TPG_FIXED): word_o = pat_i;
            3'(TPG_BAL):   word_o = cur[0] ? ~pat_i : pat_i;
            3'(TPG_CYC4): begin
                unique case (cur)
                    2'd0:    word_o = '0;
                    2'd1:    word_o = pat_i;
                    2'd2:    word_o = '1;
                    default: word_o = ~pat_i;
                endcase
            end
            default:       word_o = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) phase_q <= '0;
        else       phase_q <= cur + 1'b1;
    end
endmodule

// File: rtl/tpg_errinj.sv
module tpg_errinj (
    input  logic clk_i,
    input  logic rst_i,
    input  logic trig_i,
    output logic hit_o
);
    logic trig_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) trig_q <= 1'b0;
        else       trig_q <= trig_i;
    end

    assign hit_o = trig_i & ~trig_q;
endmodule

// File: rtl/tpg_lane.sv
module tpg_lane
    import tpg_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [2:0]        mode_i,
    input  logic [WORD_W-1:0] pat_i,
    input  logic              trig_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o
);
    logic [2:0]        mode_q;
    logic              restart;
    logic              active;
    logic              is_prbs;
    logic              hit;
    logic [WORD_W-1:0] prbs_word;
    logic [WORD_W-1:0] seq_word;
    logic [WORD_W-1:0] src;

    assign restart = (mode_i != mode_q);
    assign active  = mode_active(mode_i);
    assign is_prbs = (mode_i == 3'(TPG_PRBS15)) || (mode_i == 3'(TPG_PRBS7));

    tpg_prbs u_prbs (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .restart_i(restart),
        .short_i  (mode_i == 3'(TPG_PRBS7)),
        .word_o   (prbs_word)
    );

    tpg_seq u_seq (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .restart_i(restart),
        .mode_i   (mode_i),
        .pat_i    (pat_i),
        .word_o   (seq_word)
    );

    tpg_errinj u_err (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .trig_i(trig_i),
        .hit_o (hit)
    );

    assign src = is_prbs ? prbs_word : seq_word;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mode_q  <= 3'(TPG_OFF);
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            mode_q  <= mode_i;
            valid_o <= active;
            word_o  <= active ? (src ^ {{(WORD_W-1){1'b0}}, hit}) : '0;
        end
    end
endmodule

// File: rtl/tpg_lane_chk.sv
module tpg_lane_chk
    import tpg_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic [2:0]        mode_i,
    input logic [WORD_W-1:0] pat_i,
    input logic              trig_i,
    input logic [WORD_W-1:0] word_o,
    input logic              valid_o
);
    logic trig_d;
    logic edge_now;
    logic edge_d;
    logic [2:0] mode_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            trig_d <= 1'b0;
            edge_d <= 1'b0;
            mode_d <= 3'd0;
        end else begin
            trig_d <= trig_i;
            edge_d <= edge_now;
            mode_d <= mode_i;
        end
    end
    assign edge_now = trig_i & ~trig_d;

    // R1
    reset_quiet_chk: assert property (@(posedge clk_i)
        rst_i |=> (word_o == '0 && !valid_o));

    // R2
    off_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 3'd0 || mode_i > 3'd5) |=> (word_o == '0 && !valid_o));

    // R3
    active_valid_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i >= 3'd1 && mode_i <= 3'd5) |=> valid_o);

    // R6
    fixed_word_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 3'd3 && !edge_now) |=> (word_o == $past(pat_i)));

    // R7
    bal_flip_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 3'd4 && mode_d == 3'd4 && valid_o && !edge_now && !edge_d
         && pat_i == $past(pat_i))
        |=> (word_o == ~$past(word_o)));

    // R9
    lsb_flip_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 3'd3 && edge_now) |=> (word_o == ($past(pat_i) ^ 10'h001)));
endmodule

bind tpg_lane tpg_lane_chk u_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .mode_i (mode_i),
    .pat_i  (pat_i),
    .trig_i (trig_i),
    .word_o (word_o),
    .valid_o(valid_o)
);

// File: tb/tpg_lane_tb.sv
module tpg_lane_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] mode;
    logic [9:0] pat;
    logic       trig;
    logic [9:0] word;
    logic       valid;

    int checks = 0;
    int failures = 0;
    logic [14:0] ref_s;

    always #4 clk = ~clk;

    tpg_lane u_dut (
        .clk_i  (clk),
        .rst_i  (rst),
        .mode_i (mode),
        .pat_i  (pat),
        .trig_i (trig),
        .word_o (word),
        .valid_o(valid)
    );

    initial begin
        #1600000;
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input string req, input logic [9:0] exp_w, input logic exp_v);
        checks++;
        if (word !== exp_w || valid !== exp_v) begin
            failures++;
            $display("FAIL %s word=%h valid=%b expected word=%h valid=%b",
                     req, word, valid, exp_w, exp_v);
        end
    endtask

    // inputs change at negedge; one call advances through one posedge
    task automatic cyc();
        @(negedge clk);
    endtask

    // bench model of the sequence generator
    function automatic logic [9:0] ref_word(input logic short_p);
        logic [9:0] w;
        logic b;
        for (int k = 0; k < 10; k++) begin
            b = short_p ? (ref_s[6] ^ ref_s[5]) : (ref_s[14] ^ ref_s[13]);
            ref_s = {ref_s[13:0], b};
            w[k] = b;
        end
        return w;
    endfunction

    task automatic go_off();
        mode = 3'd0; trig = 1'b0; cyc();
    endtask

    task automatic t_reset();
        rst = 1'b1; mode = 3'd0; pat = 10'h000; trig = 1'b0;
        cyc(); cyc();
        chk("R1 in reset", 10'h000, 1'b0);
        rst = 1'b0;
        cyc();
        chk("R1 after reset", 10'h000, 1'b0);
    endtask

    task automatic t_off();
        pat = 10'h2A5; mode = 3'd0; trig = 1'b1;
        cyc(); chk("R2 mode0 with trig", 10'h000, 1'b0);
        trig = 1'b0; mode = 3'd6;
        cyc(); chk("R2 mode6", 10'h000, 1'b0);
        mode = 3'd7; trig = 1'b1;
        cyc(); chk("R2 mode7 with trig", 10'h000, 1'b0);
        go_off();
    endtask

    task automatic t_prbs(input logic [2:0] m, input string req);
        logic [9:0] e;
        ref_s = '1;
        mode = m;
        for (int i = 0; i < 24; i++) begin
            cyc();
            e = ref_word(m == 3'd2);
            chk(req, e, 1'b1);
        end
        go_off();
    endtask

    task automatic t_fixed();
        mode = 3'd3; pat = 10'h1C3;
        cyc(); chk("R6 fixed", 10'h1C3, 1'b1);
        cyc(); chk("R6 fixed R3", 10'h1C3, 1'b1);
        pat = 10'h2F0;
        cyc(); chk("R6 fixed new pat", 10'h2F0, 1'b1);
        go_off();
    endtask

    task automatic t_bal();
        pat = 10'h0F3; mode = 3'd4;
        for (int i = 0; i < 6; i++) begin
            cyc();
            chk("R7 balanced", (i % 2 == 0) ? 10'h0F3 : 10'h30C, 1'b1);
        end
        go_off();
    endtask

    task automatic t_cyc();
        logic [9:0] e;
        pat = 10'h155; mode = 3'd5;
        for (int i = 0; i < 9; i++) begin
            cyc();
            case (i % 4)
                0: e = 10'h000;
                1: e = 10'h155;
                2: e = 10'h3FF;
                default: e = 10'h2AA;
            endcase
            chk("R8 four-word cycle", e, 1'b1);
        end
        go_off();
    endtask

    task automatic t_err();
        logic [9:0] e;
        pat = 10'h246; mode = 3'd3;
        cyc(); chk("R9 before trig", 10'h246, 1'b1);
        trig = 1'b1;
        cyc(); chk("R9 lsb flipped", 10'h247, 1'b1);
        cyc(); chk("R9 held trig no effect", 10'h246, 1'b1);
        cyc(); chk("R9 held trig no effect", 10'h246, 1'b1);
        trig = 1'b0;
        cyc(); chk("R9 after release", 10'h246, 1'b1);
        go_off();
        // error in PRBS7 stream
        ref_s = '1; mode = 3'd2;
        cyc(); e = ref_word(1'b1); chk("R9 prbs7 clean", e, 1'b1);
        trig = 1'b1;
        cyc(); e = ref_word(1'b1); chk("R9 prbs7 flipped", e ^ 10'h001, 1'b1);
        cyc(); e = ref_word(1'b1); chk("R9 prbs7 one word only", e, 1'b1);
        go_off();
    endtask

    task automatic t_restart();
        logic [9:0] first;
        ref_s = '1;
        first = ref_word(1'b0);
        mode = 3'd1;
        for (int i = 0; i < 5; i++) cyc();
        mode = 3'd4; pat = 10'h011;
        cyc(); chk("R10 enter balanced", 10'h011, 1'b1);
        mode = 3'd1;
        cyc(); chk("R10 prbs15 reseeded", first, 1'b1);
        mode = 3'd4;
        cyc(); chk("R10 balanced restarts at pat", 10'h011, 1'b1);
        cyc(); chk("R10 balanced second", 10'h3EE, 1'b1);
        mode = 3'd5;
        cyc(); chk("R10 cycle restarts at zero", 10'h000, 1'b1);
        go_off();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_off();
        t_prbs(3'd1, "R4 prbs15");
        t_prbs(3'd2, "R5 prbs7");
        t_fixed();
        t_bal();
        t_cyc();
        t_err();
        t_restart();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule